// File: doc/BRIEF.md
# Prefixed Rotate, Shift and Bit Execution Unit

This unit executes the second-byte operation group of an 8-bit processor that handles rotates, shifts and single-bit manipulation. Each operation takes one opcode byte, one 8-bit operand and the current flag register. It returns the new operand value, the new flag register, a store enable and the destination selector. Fetching bytes, handling prefixes and reading or writing memory all belong to the surrounding core. The core only presents the operand, and later writes `res_data` back when `res_store` is high.

The opcode is split into three fields. Bits 7:6 pick the class. Bits 5:3 pick either the rotate/shift kind or the bit index. Bits 2:0 name the destination register. All eight shift encodings are implemented, including the seldom-listed left shift that fills bit 0 with one.

An operation is captured on the clock edge where `op_valid` is high. Its outputs are held in registers until the next accepted operation.

Top module: `cb_exec_unit`

## Requirements
- R1: An operation presented with `op_valid` high at a rising edge appears on the outputs with `res_valid` high right after that edge. After an edge with `op_valid` low, `res_valid` is low and `res_data`, `res_flags`, `res_store` and the destination outputs keep their values.
- R2: While `rst_n` is low, every output is zero.
- R3: Class 00 (bits 7:6) with kind field (bits 5:3) set to 000, 001, 010 or 011 performs the following on the operand. 000 rotates left, with old bit 7 going to bit 0 and to carry. 001 rotates right, with old bit 0 going to bit 7 and to carry. 010 rotates left through carry: the incoming carry (flag bit 0) enters bit 0 and old bit 7 becomes the carry. 011 rotates right through carry: the incoming carry enters bit 7 and old bit 0 becomes the carry.
- R4: Class 00 with kind 100 shifts left, filling bit 0 with zero and moving old bit 7 to carry. Kind 101 shifts right and keeps bit 7. Kind 111 shifts right and fills bit 7 with zero. For both right shifts, old bit 0 goes to carry.
- R5: Class 00 with kind 110 shifts left, sets bit 0 to one and moves old bit 7 to carry.
- R6: The flag register layout is S=bit 7, Z=6, H=4, P/V=2, N=1, C=0. For class 00, the flags are set as follows. S is result bit 7. Z is set when the result is zero. H and N are cleared. P/V is set when the result has an even number of ones. C is as given in R3 to R5.
- R7: Class 01 tests operand bit n, where n is bits 5:3. The data output equals the operand. The flags are set as follows. Z is set when that bit is 0. P/V equals Z. S is set only when n is 7 and operand bit 7 is one. H is set, N is cleared, and C keeps the incoming carry.
- R8: Class 10 clears operand bit n and class 11 sets operand bit n. All other bits are unchanged. The output flags equal the incoming flags.
- R9: `res_store` is high for classes 00, 10 and 11 and low for class 01. `res_dest` is opcode bits 2:0. `res_dest_mem` is high when that field is 110 (memory operand; 000..101 and 111 name registers B, C, D, E, H, L, A).
- R10: Flag bits 5 and 3 always pass through from `flags_in` unchanged, in every class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Accept the presented operation at this edge |
| op_code | input | 8 | Second opcode byte |
| operand | input | 8 | Operand value |
| flags_in | input | 8 | Current flag register |
| res_valid | output | 1 | A result was captured at the last edge |
| res_data | output | 8 | Result value |
| res_flags | output | 8 | Updated flag register |
| res_store | output | 1 | Result must be written back |
| res_dest | output | 3 | Destination field from the opcode |
| res_dest_mem | output | 1 | Destination is the memory operand |

## Verification
The bench sweeps all 256 opcodes over operands 00, FF and random values, using both carry values. Directed cases target the following boundaries:
- The fill-with-one left shift of 80 must give 01 with carry set. A design that decodes that kind as a plain left shift or as a no-op leaves bit 0 clear.
- The arithmetic right shift of 80 must give C0. A design that treats it as a logical shift drops the sign.
- Rotate-through-carry with an incoming carry must show the carry in the vacated bit. A design that confuses the two rotate families recirculates the outgoing bit instead.
- Bit tests on bit 7 exercise the sign rule, and bit tests must not raise the store enable.
- Bit set and clear must return the incoming flags untouched.
- Idle cycles must leave the held result stable.

// File: rtl/cb_exec_unit.sv
module cb_exec_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [7:0] op_code,
  input  logic [7:0] operand,
  input  logic [7:0] flags_in,
  output logic       res_valid,
  output logic [7:0] res_data,
  output logic [7:0] res_flags,
  output logic       res_store,
  output logic [2:0] res_dest,
  output logic       res_dest_mem
);
  localparam int FS = 7;
  localparam int FZ = 6;
  localparam int FH = 4;
  localparam int FP = 2;
  localparam int FN = 1;
  localparam int FC = 0;
  localparam logic [2:0] MEM_SEL = 3'b110;

  logic [1:0] cls;
  logic [2:0] fld;
  logic       cin;
  logic [7:0] mask;
  logic [7:0] sh_val;
  logic       sh_out;
  logic       bit_hit;
  logic [7:0] nxt_data;
  logic [7:0] nxt_flags;

  assign cls     = op_code[7:6];
  assign fld     = op_code[5:3];
  assign cin     = flags_in[FC];
  assign mask    = 8'd1 << fld;
  assign bit_hit = |(operand & mask);

  always_comb begin
    sh_out = operand[7];
    case (fld)
      3'd0: sh_val = {operand[6:0], operand[7]};
      3'd1: begin sh_val = {operand[0], operand[7:1]}; sh_out = operand[0]; end
      3'd2: sh_val = {operand[6:0], cin};
      3'd3: begin sh_val = {cin, operand[7:1]};        sh_out = operand[0]; end
      3'd4: sh_val = {operand[6:0], 1'b0};
      3'd5: begin sh_val = {operand[7], operand[7:1]}; sh_out = operand[0]; end
      3'd6: sh_val = {operand[6:0], 1'b1};
      default: begin sh_val = {1'b0, operand[7:1]};    sh_out = operand[0]; end
    endcase
  end

  always_comb begin
    nxt_flags = flags_in;
    nxt_data  = operand;
    case (cls)
      2'b00: begin
        nxt_data      = sh_val;
        nxt_flags[FS] = sh_val[7];
        nxt_flags[FZ] = (sh_val == 8'h00);
        nxt_flags[FH] = 1'b0;
        nxt_flags[FP] = ~^sh_val;
        nxt_flags[FN] = 1'b0;
        nxt_flags[FC] = sh_out;
      end
      2'b01: begin
        nxt_flags[FS] = (fld == 3'd7) && bit_hit;
        nxt_flags[FZ] = ~bit_hit;
        nxt_flags[FH] = 1'b1;
        nxt_flags[FP] = ~bit_hit;
        nxt_flags[FN] = 1'b0;
      end
      2'b10:   nxt_data = operand & ~mask;
      default: nxt_data = operand | mask;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_data     <= '0;
      res_flags    <= '0;
      res_store    <= 1'b0;
      res_dest     <= '0;
      res_dest_mem <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_data     <= nxt_data;
        res_flags    <= nxt_flags;
        res_store    <= (cls != 2'b01);
        res_dest     <= op_code[2:0];
        res_dest_mem <= (op_code[2:0] == MEM_SEL);
      end
    end
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && $stable(res_data) && $stable(res_flags) && $stable(res_store)));
  assert_fill_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[7:3] == 5'b00110) |=> (res_data[0] && res_flags[FC] == $past(operand[7])));
  assert_shift_hn_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[7:6] == 2'b00) |=> (!res_flags[FH] && !res_flags[FN]));
  assert_test_no_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[7:6] == 2'b01) |=> (!res_store && res_data == $past(operand)
                                            && res_flags[FC] == $past(flags_in[FC])));
  assert_setres_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[7]) |=> (res_flags == $past(flags_in)));
  assert_setres_one_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[7]) |=> ($countones(res_data ^ $past(operand)) <= 1));
  assert_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (res_flags[5] == $past(flags_in[5]) && res_flags[3] == $past(flags_in[3])));
endmodule

// File: tb/sim_cb_exec_unit.sv
module sim_cb_exec_unit;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [7:0] op_code = '0;
  logic [7:0] operand = '0;
  logic [7:0] flags_in = '0;
  logic       res_valid;
  logic [7:0] res_data;
  logic [7:0] res_flags;
  logic       res_store;
  logic [2:0] res_dest;
  logic       res_dest_mem;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  cb_exec_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .flags_in(flags_in), .res_valid(res_valid),
    .res_data(res_data), .res_flags(res_flags), .res_store(res_store),
    .res_dest(res_dest), .res_dest_mem(res_dest_mem)
  );

  // returns {dest_mem, dest[2:0], store, data[7:0], flags[7:0]}
  function automatic logic [20:0] model(input logic [7:0] op, input logic [7:0] a, input logic [7:0] f);
    logic [7:0] r;
    logic [7:0] fo;
    logic       co;
    logic       st;
    int         ones;
    int         k;
    k  = int'(op[5:3]);
    fo = f;
    r  = a;
    co = f[0];
    st = (op[7:6] != 2'b01);
    if (op[7:6] == 2'b00) begin
      case (k)
        0: begin r = (a << 1) | (a >> 7); co = a[7]; end
        1: begin r = (a >> 1) | (a << 7); co = a[0]; end
        2: begin r = (a << 1) | {7'd0, f[0]}; co = a[7]; end
        3: begin r = (a >> 1) | {f[0], 7'd0}; co = a[0]; end
        4: begin r = a << 1; co = a[7]; end
        5: begin r = (a >> 1) | (a & 8'h80); co = a[0]; end
        6: begin r = (a << 1) + 8'd1; co = a[7]; end
        default: begin r = a >> 1; co = a[0]; end
      endcase
      ones = 0;
      for (int i = 0; i < 8; i++) ones += int'(r[i]);
      fo[7] = r[7];
      fo[6] = (r == 0);
      fo[4] = 1'b0;
      fo[2] = (ones % 2 == 0);
      fo[1] = 1'b0;
      fo[0] = co;
    end else if (op[7:6] == 2'b01) begin
      fo[6] = (a[k] == 1'b0);
      fo[2] = fo[6];
      fo[7] = (k == 7) && a[7];
      fo[4] = 1'b1;
      fo[1] = 1'b0;
    end else if (op[7:6] == 2'b10) begin
      r[k] = 1'b0;
    end else begin
      r[k] = 1'b1;
    end
    return {(op[2:0] == 3'd6), op[2:0], st, r, fo};
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    if (op[7:6] == 2'b01) return "R7";
    if (op[7:6] != 2'b00) return "R8";
    if (op[5:3] == 3'd6) return "R5";
    if (op[5]) return "R4";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [20:0] got, input logic [20:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] op, input logic [7:0] a, input logic [7:0] f, input string tag);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; operand = a; flags_in = f;
    @(negedge clk);
    op_valid = 1'b0;
    check(tag, {res_dest_mem, res_dest, res_store, res_data, res_flags}, model(op, a, f));
    check("R1", {20'd0, res_valid}, 21'd1);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [20:0] held;
    void'($urandom(32'd4242));
    #(CLK_P * 3);
    check("R2", {res_dest_mem, res_dest, res_store, res_data, res_flags, res_valid} , 21'd0);
    @(negedge clk); rst_n = 1'b1;

    // directed corners
    run_op(8'h36, 8'h80, 8'h00, "R5");   // fill-one shift: 80 -> 01, C=1
    run_op(8'h2F, 8'h80, 8'h00, "R4");   // arithmetic right: 80 -> C0
    run_op(8'h3E, 8'h01, 8'h00, "R4");   // logical right: 01 -> 00, Z and C
    run_op(8'h1F, 8'h01, 8'h01, "R3");   // rotate right through carry: 80, C=1
    run_op(8'h10, 8'h00, 8'h01, "R3");   // rotate left through carry: 01
    run_op(8'h7E, 8'h80, 8'hFF, "R7");   // test bit 7 set: S=1
    run_op(8'h47, 8'hFE, 8'h28, "R7");   // test bit 0 clear: Z=1, no store
    run_op(8'h86, 8'hFF, 8'hD7, "R8");   // clear bit 0
    run_op(8'hFF, 8'h00, 8'h28, "R8");   // set bit 7, A destination
    run_op(8'h06, 8'h55, 8'h28, "R10");  // pass-through of bits 5 and 3
    run_op(8'hCE, 8'h00, 8'h00, "R9");   // memory destination

    // idle hold
    held = {res_dest_mem, res_dest, res_store, res_data, res_flags};
    @(negedge clk); operand = 8'hA5; op_code = 8'h00; flags_in = 8'hFF;
    @(negedge clk);
    check("R1", {res_dest_mem, res_dest, res_store, res_data, res_flags}, held);
    check("R1", {20'd0, res_valid}, 21'd0);

    // full sweep
    for (int op = 0; op < 256; op++) begin
      for (int rep = 0; rep < 4; rep++) begin
        for (int c = 0; c < 2; c++) begin
          logic [7:0] a;
          logic [7:0] f;
          a = (rep == 0) ? 8'h00 : (rep == 1) ? 8'hFF : 8'($urandom);
          f = {8'($urandom)} & 8'hFE | 8'(c);
          run_op(8'(op), a, f, tag_of(8'(op)));
        end
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule